// File: doc/BRIEF.md
# Four-Channel Blank-Triggered DMA Engine

This block moves blocks of 16-bit or 32-bit units from one address range to another without processor help. Four channels each hold a programmed source address, destination address, unit count and control word. When a channel fires, the engine reads one unit from the source and writes it to the destination. It repeats this until the count is used up, stepping each address as the channel's address mode says.

A channel fires at once when software sets its enable bit, or on the next horizontal-blank or vertical-blank strobe. One shared mover serves the channels one block at a time, and the lowest-numbered waiting channel goes first. When a block finishes, a channel in single-shot mode drops its own enable bit. A channel in repeat mode reloads its count, and reloads its destination if asked to, then waits for its next strobe. Each channel can pulse its own interrupt line when a block ends.

Software writes registers through a small port that selects a channel and a register. Register select 0 is the source, 1 the destination, 2 the count and 3 the control word. The control word of the selected channel reads back at all times.

Top module: `quad_dma_engine`

## Requirements
- R1: Writing the source or destination register stores the value with bit 0 cleared. A 32-bit channel additionally clears bit 1 of both working addresses when its block starts.
- R2: On channels 0 to 2 the count is the low 14 bits of the written value. On channel 3 it is the low 16 bits. A count of zero means 0x4000 units on channels 0 to 2 and 0x10000 units on channel 3.
- R3: The 2-bit address mode takes these codes: 0 adds the unit size after each unit, 1 subtracts it, 2 holds the address, and 3 adds it (with a destination reload on repeat). The unit size is 2 bytes, or 4 bytes when control bit 5 is set. The source mode is in control bits 3:2 and the destination mode in bits 1:0.
- R4: The working source, destination and count are copied from the programmed registers only when control bit 15 (enable) goes from 0 to 1. A register write while the channel is enabled does not change a block already armed.
- R5: Control bits 7:6 select the start: 0 at enable, 1 on a horizontal-blank strobe, 2 on a vertical-blank strobe. Code 3 never starts a transfer, whatever the strobes do.
- R6: A blank strobe arms every enabled channel set to that strobe, and nothing else. The armed channels run one after another, lowest channel number first.
- R7: Without repeat (control bit 4 clear), the end of a block clears the enable bit. The control readback then shows bit 15 as 0, with all other stored fields unchanged. Unused control bits read as 0, and every control word reads 0 after reset.
- R8: With repeat set, the end of a block reloads the count and keeps the channel enabled. The destination restarts from its programmed value only in destination mode 3; otherwise both addresses continue from where the block ended. A blank-triggered channel waits for its next strobe. A channel that starts at enable does not run again.
- R9: If control bit 8 is set, the channel's interrupt line goes high for exactly one cycle per finished block. If bit 8 is clear, the line stays low.
- R10: A channel whose enable is cleared before its trigger arrives makes no bus access.
- R11: Each unit is a read from the source followed by a write to the destination. The request, address and direction hold steady until ready is seen high. For 16-bit units the data sits in bits 15:0 and bits 31:16 of the write data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel selected for write and readback |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 16 | Control word of the selected channel |
| hblank | input | 1 | Horizontal-blank strobe |
| vblank | input | 1 | Vertical-blank strobe |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_wide | output | 1 | 1 for a 32-bit unit, 0 for 16-bit |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ready | input | 1 | Completes the current request |
| irq | output | 4 | Per-channel block-done pulses |

## Verification
Reset passes through a two-stage synchronizer, so registers respond from the third rising edge after rst_n goes high. A control write sampled at one edge arms the channel at that edge, and the first read request appears after the following edge. The write that ends a block is accepted at an edge E. One edge later the enable bit clears and the interrupt line is high for the next cycle only. The bench drives and samples on falling edges and logs writes and interrupts every cycle. It reads the write log and the control readback only after six cycles without a bus request, so every register update is already in place when it compares.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    ADJ_INC        = 2'd0,
    ADJ_DEC        = 2'd1,
    ADJ_HOLD       = 2'd2,
    ADJ_INC_RELOAD = 2'd3
  } adj_e;

  typedef enum logic [1:0] {
    TRIG_NOW  = 2'd0,
    TRIG_HBL  = 2'd1,
    TRIG_VBL  = 2'd2,
    TRIG_SPCL = 2'd3
  } trig_e;

  typedef struct packed {
    logic  en;
    logic  irq_en;
    trig_e trig;
    logic  wide;
    logic  rpt;
    adj_e  sadj;
    adj_e  dadj;
  } chan_ctl_t;

  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  function automatic chan_ctl_t ctl_unpack(input logic [15:0] w);
    chan_ctl_t c;
    c.en     = w[15];
    c.irq_en = w[8];
    c.trig   = trig_e'(w[7:6]);
    c.wide   = w[5];
    c.rpt    = w[4];
    c.sadj   = adj_e'(w[3:2]);
    c.dadj   = adj_e'(w[1:0]);
    return c;
  endfunction

  function automatic logic [15:0] ctl_pack(input chan_ctl_t c);
    return {c.en, 6'b0, c.irq_en, c.trig, c.wide, c.rpt, c.sadj, c.dadj};
  endfunction
endpackage

// File: rtl/dmac_prio.sv
module dmac_prio #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 17,
  parameter int FW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [31:0]   wdata,
  input  logic          hbl,
  input  logic          vbl,
  input  logic          start,
  input  logic          done,
  input  logic [AW-1:0] fin_src,
  input  logic [AW-1:0] fin_dst,
  output logic          pend,
  output chan_ctl_t     ctl,
  output logic [AW-1:0] wsrc,
  output logic [AW-1:0] wdst,
  output logic [CW-1:0] wcnt,
  output logic          irq,
  output logic [15:0]   ctl_rd
);
  localparam logic [CW-1:0] MAXC = {{(CW-1){1'b0}}, 1'b1} << FW;

  logic [AW-1:0] src_q, src_n, dst_q, dst_n, nsrc_q, nsrc_n, ndst_q, ndst_n;
  logic [CW-1:0] cnt_q, cnt_n, ncnt_q, ncnt_n;
  chan_ctl_t     ctl_q, ctl_n;
  logic          pend_q, pend_n, irq_q, irq_n;
  logic          rise, fire;
  logic [FW-1:0] fld;

  assign fld  = wdata[FW-1:0];
  assign rise = we && (sel == SEL_CTL) && wdata[15] && !ctl_q.en;

  always_comb begin
    src_n  = src_q;   dst_n  = dst_q;   cnt_n  = cnt_q;   ctl_n = ctl_q;
    nsrc_n = nsrc_q;  ndst_n = ndst_q;  ncnt_n = ncnt_q;
    pend_n = pend_q;  irq_n  = 1'b0;
    if (we) begin
      case (sel)
        SEL_SRC: src_n = {wdata[AW-1:1], 1'b0};
        SEL_DST: dst_n = {wdata[AW-1:1], 1'b0};
        SEL_CNT: cnt_n = (fld == '0) ? MAXC : {{(CW-FW){1'b0}}, fld};
        default: ctl_n = ctl_unpack(wdata[15:0]);
      endcase
    end
    if (rise) begin
      nsrc_n = src_q;
      ndst_n = dst_q;
      ncnt_n = cnt_q;
    end
    if (start) pend_n = 1'b0;
    if (done) begin
      nsrc_n = fin_src;
      ndst_n = fin_dst;
      ncnt_n = '0;
      irq_n  = ctl_q.irq_en;
      if (ctl_q.rpt) begin
        ncnt_n = cnt_q;
        if (ctl_q.dadj == ADJ_INC_RELOAD) ndst_n = dst_q;
      end else begin
        ctl_n.en = 1'b0;
      end
    end
    fire = ctl_n.en && ((rise && ctl_n.trig == TRIG_NOW) ||
                        (hbl  && ctl_n.trig == TRIG_HBL) ||
                        (vbl  && ctl_n.trig == TRIG_VBL));
    if (fire)      pend_n = 1'b1;
    if (!ctl_n.en) pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;  dst_q <= '0;  cnt_q <= MAXC;  ctl_q <= '0;
      nsrc_q <= '0; ndst_q <= '0; ncnt_q <= MAXC;
      pend_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      src_q <= src_n;   dst_q <= dst_n;   cnt_q <= cnt_n;   ctl_q <= ctl_n;
      nsrc_q <= nsrc_n; ndst_q <= ndst_n; ncnt_q <= ncnt_n;
      pend_q <= pend_n; irq_q <= irq_n;
    end
  end

  assign pend   = pend_q;
  assign ctl    = ctl_q;
  assign wsrc   = nsrc_q;
  assign wdst   = ndst_q;
  assign wcnt   = ncnt_q;
  assign irq    = irq_q;
  assign ctl_rd = ctl_pack(ctl_q);

  // R7: a single-shot block end drops the enable bit
  a_r7_done_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctl_q.rpt && !(we && sel == SEL_CTL)) |=> !ctl_q.en);
  // R9: interrupt is never longer than one cycle
  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R10: a disabled channel never waits for service
  a_r10_off_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.en |-> !pend_q);
  // R2: an enabled channel always holds a non-zero working count
  a_r2_live_count: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.en |-> (ncnt_q != '0));
endmodule

// File: rtl/dmac_mover.sv
module dmac_mover
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int CW  = 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          pend,
  input  chan_ctl_t [NCH-1:0]     ctl,
  input  logic [NCH-1:0][AW-1:0]  wsrc,
  input  logic [NCH-1:0][AW-1:0]  wdst,
  input  logic [NCH-1:0][CW-1:0]  wcnt,
  output logic [NCH-1:0]          start,
  output logic [NCH-1:0]          done,
  output logic [AW-1:0]           fin_src,
  output logic [AW-1:0]           fin_dst,
  output logic                    bus_req,
  output logic                    bus_we,
  output logic                    bus_wide,
  output logic [AW-1:0]           bus_addr,
  output logic [31:0]             bus_wdata,
  input  logic [31:0]             bus_rdata,
  input  logic                    bus_ready
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [1:0] {MV_IDLE, MV_RD, MV_WR, MV_FIN} mv_e;

  mv_e           st_q, st_n;
  logic [IW-1:0] ch_q, ch_n, idx;
  logic [AW-1:0] sa_q, sa_n, da_q, da_n;
  logic [CW-1:0] left_q, left_n;
  logic [31:0]   buf_q, buf_n;
  logic          wide_q, wide_n, any;
  adj_e          sadj_q, sadj_n, dadj_q, dadj_n;
  logic [NCH-1:0] gnt;

  dmac_prio #(.N(NCH)) u_prio (.req(pend), .gnt(gnt), .idx(idx), .any(any));

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] a, input adj_e m, input logic w);
    logic [AW-1:0] u;
    u = w ? AW'(4) : AW'(2);
    case (m)
      ADJ_DEC:  return a - u;
      ADJ_HOLD: return a;
      default:  return a + u;
    endcase
  endfunction

  always_comb begin
    st_n = st_q;  ch_n = ch_q;  sa_n = sa_q;  da_n = da_q;  left_n = left_q;
    buf_n = buf_q;  wide_n = wide_q;  sadj_n = sadj_q;  dadj_n = dadj_q;
    case (st_q)
      MV_IDLE: if (any) begin
        st_n   = MV_RD;
        ch_n   = idx;
        wide_n = ctl[idx].wide;
        sadj_n = ctl[idx].sadj;
        dadj_n = ctl[idx].dadj;
        sa_n   = ctl[idx].wide ? {wsrc[idx][AW-1:2], 2'b00} : wsrc[idx];
        da_n   = ctl[idx].wide ? {wdst[idx][AW-1:2], 2'b00} : wdst[idx];
        left_n = wcnt[idx];
      end
      MV_RD: if (bus_ready) begin
        buf_n = wide_q ? bus_rdata : {16'h0, bus_rdata[15:0]};
        st_n  = MV_WR;
      end
      MV_WR: if (bus_ready) begin
        sa_n   = adv(sa_q, sadj_q, wide_q);
        da_n   = adv(da_q, dadj_q, wide_q);
        left_n = left_q - 1'b1;
        st_n   = (left_q == CW'(1)) ? MV_FIN : MV_RD;
      end
      default: st_n = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= MV_IDLE;  ch_q <= '0;  sa_q <= '0;  da_q <= '0;  left_q <= '0;
      buf_q <= '0;  wide_q <= 1'b0;  sadj_q <= ADJ_INC;  dadj_q <= ADJ_INC;
    end else begin
      st_q <= st_n;  ch_q <= ch_n;  sa_q <= sa_n;  da_q <= da_n;  left_q <= left_n;
      buf_q <= buf_n;  wide_q <= wide_n;  sadj_q <= sadj_n;  dadj_q <= dadj_n;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_hs
    assign start[i] = (st_q == MV_IDLE) && gnt[i];
    assign done[i]  = (st_q == MV_FIN) && (ch_q == IW'(i));
  end

  assign fin_src   = sa_q;
  assign fin_dst   = da_q;
  assign bus_req   = (st_q == MV_RD) || (st_q == MV_WR);
  assign bus_we    = (st_q == MV_WR);
  assign bus_wide  = wide_q;
  assign bus_addr  = (st_q == MV_WR) ? da_q : sa_q;
  assign bus_wdata = buf_q;

  // R11: request held steady until ready
  a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));
  // R11: 16-bit writes carry zero in the upper half
  a_r11_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !bus_wide) |-> (bus_wdata[31:16] == 16'h0));
  // R1: 32-bit accesses are word aligned
  a_r1_wide_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wide) |-> (bus_addr[1:0] == 2'b00));
  // R6: at most one channel granted per cycle
  a_r6_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start));
endmodule

// File: rtl/quad_dma_engine.sv
module quad_dma_engine
  import dmac_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int AW       = 32,
  parameter int LO_CNT_W = 14,
  parameter int HI_CNT_W = 16,
  localparam int CW      = HI_CNT_W + 1,
  localparam int IW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [31:0]    cfg_wdata,
  output logic [15:0]    cfg_rdata,
  input  logic           hblank,
  input  logic           vblank,
  output logic           bus_req,
  output logic           bus_we,
  output logic           bus_wide,
  output logic [AW-1:0]  bus_addr,
  output logic [31:0]    bus_wdata,
  input  logic [31:0]    bus_rdata,
  input  logic           bus_ready,
  output logic [NCH-1:0] irq
);
  logic                   rs0_q, rs1_q;
  logic [NCH-1:0]         pend, start, done;
  chan_ctl_t [NCH-1:0]    ctl;
  logic [NCH-1:0][AW-1:0] wsrc, wdst;
  logic [NCH-1:0][CW-1:0] wcnt;
  logic [NCH-1:0][15:0]   ctl_rd;
  logic [AW-1:0]          fin_src, fin_dst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int FW = (i == NCH - 1) ? HI_CNT_W : LO_CNT_W;
    dmac_chan #(.AW(AW), .CW(CW), .FW(FW)) u_chan (
      .clk(clk), .rst_n(rs1_q),
      .we(cfg_we && (cfg_ch == IW'(i))), .sel(cfg_sel), .wdata(cfg_wdata),
      .hbl(hblank), .vbl(vblank), .start(start[i]), .done(done[i]),
      .fin_src(fin_src), .fin_dst(fin_dst),
      .pend(pend[i]), .ctl(ctl[i]), .wsrc(wsrc[i]), .wdst(wdst[i]),
      .wcnt(wcnt[i]), .irq(irq[i]), .ctl_rd(ctl_rd[i])
    );
  end

  dmac_mover #(.NCH(NCH), .AW(AW), .CW(CW)) u_mover (
    .clk(clk), .rst_n(rs1_q), .pend(pend), .ctl(ctl),
    .wsrc(wsrc), .wdst(wdst), .wcnt(wcnt),
    .start(start), .done(done), .fin_src(fin_src), .fin_dst(fin_dst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  assign cfg_rdata = ctl_rd[cfg_ch];
endmodule

// File: tb/quad_dma_engine_bench.sv
`timescale 1ns/1ps
module quad_dma_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = 2'd0, cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [15:0] cfg_rdata;
  logic        hblank = 1'b0, vblank = 1'b0;
  logic        bus_req, bus_we, bus_wide;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_ready = 1'b1;
  logic        stall = 1'b0;
  logic [3:0]  irq, irq_prev = 4'h0;

  int n_cmp = 0, n_bad = 0, cyc = 0, wr_total = 0, irq_wide_err = 0;
  int irq_cnt [4];
  logic [31:0] log_a [64];
  logic [31:0] log_d [64];

  always #4 clk = ~clk;

  quad_dma_engine u_quad_dma_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hblank(hblank), .vblank(vblank),
    .bus_req(bus_req), .bus_we(bus_we), .bus_wide(bus_wide), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .irq(irq)
  );

  function automatic logic [31:0] mv(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0] + 16'h1357};
  endfunction

  function automatic logic [31:0] expd(input logic [31:0] a, input logic wide);
    logic [31:0] v;
    v = mv(a);
    return wide ? v : {16'h0, v[15:0]};
  endfunction

  assign bus_rdata = mv(bus_addr);

  always @(negedge clk) begin
    cyc++;
    if (bus_req && bus_we && bus_ready) begin
      if (wr_total < 64) begin
        log_a[wr_total] = bus_addr;
        log_d[wr_total] = bus_wdata;
      end
      wr_total++;
    end
    for (int c = 0; c < 4; c++) begin
      if (irq[c]) irq_cnt[c]++;
      if (irq[c] && irq_prev[c]) irq_wide_err++;
    end
    irq_prev = irq;
    bus_ready = stall ? ~bus_ready : 1'b1;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    while (cyc < 190000) @(negedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    summary();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] ch, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input logic [1:0] ch, input logic [31:0] s, input logic [31:0] d,
                      input logic [15:0] n, input logic [15:0] c);
    wr(ch, 2'd0, s); wr(ch, 2'd1, d); wr(ch, 2'd2, {16'h0, n}); wr(ch, 2'd3, {16'h0, c});
  endtask

  task automatic quiet();
    int q = 0;
    while (q < 6) begin
      @(negedge clk);
      q = bus_req ? 0 : q + 1;
    end
  endtask

  task automatic clr();
    wr_total = 0;
    for (int c = 0; c < 4; c++) irq_cnt[c] = 0;
  endtask

  task automatic strobe(input logic h);
    @(negedge clk);
    if (h) hblank = 1'b1; else vblank = 1'b1;
    @(negedge clk);
    hblank = 1'b0; vblank = 1'b0;
  endtask

  function automatic logic [15:0] rdback(input logic [1:0] ch);
    cfg_ch = ch;
    return cfg_rdata;
  endfunction

  typedef struct packed {
    logic [1:0]  ch;
    logic [31:0] src, dst;
    logic [15:0] cnt, ctl;
    logic [16:0] n;
    logic [31:0] dfirst, dlast, slast;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{2'd0, 32'h1000, 32'h2000, 16'd4,      16'h8100, 17'd4, 32'h2000, 32'h2006, 32'h1006},
    '{2'd1, 32'h3003, 32'h4006, 16'd3,      16'h8124, 17'd3, 32'h4004, 32'h400C, 32'h2FF8},
    '{2'd2, 32'h5000, 32'h6000, 16'd5,      16'h8109, 17'd5, 32'h6000, 32'h5FF8, 32'h5000},
    '{2'd3, 32'h7001, 32'h8000, 16'd2,      16'h812E, 17'd2, 32'h8000, 32'h8000, 32'h7004},
    '{2'd2, 32'h9000, 32'hA000, 16'h4001,   16'h8100, 17'd1, 32'hA000, 32'hA000, 32'h9000}
  };

  initial begin
    for (int c = 0; c < 4; c++) irq_cnt[c] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state (R7 readback, R11 idle bus, R9 quiet lines)
    for (int c = 0; c < 4; c++) chk("R7 reset ctl", {16'h0, rdback(2'(c))}, 32'h0);
    chk("R11 reset bus_req", {31'h0, bus_req}, 32'h0);
    chk("R9 reset irq", {28'h0, irq}, 32'h0);

    // Vector table: immediate single-shot blocks (R1 R2 R3 R7 R9 R11)
    for (int v = 0; v < 5; v++) begin
      clr();
      stall = v[0];
      prog(VEC[v].ch, VEC[v].src, VEC[v].dst, VEC[v].cnt, VEC[v].ctl);
      quiet();
      stall = 1'b0;
      chk("R2 unit count", wr_total, {15'h0, VEC[v].n});
      chk("R1 R3 first dst", log_a[0], VEC[v].dfirst);
      chk("R3 last dst", log_a[VEC[v].n - 1], VEC[v].dlast);
      chk("R11 last data", log_d[VEC[v].n - 1], expd(VEC[v].slast, VEC[v].ctl[5]));
      chk("R7 enable cleared", {16'h0, rdback(VEC[v].ch)}, {16'h0, VEC[v].ctl & 16'h01FF});
      chk("R9 one pulse", irq_cnt[VEC[v].ch], 32'd1);
    end

    // R2: zero count means maximum, per channel
    clr(); prog(2'd0, 32'h100, 32'h200, 16'h0, 16'h800A); quiet();
    chk("R2 ch0 zero count", wr_total, 32'h4000);
    clr(); prog(2'd3, 32'h100, 32'h200, 16'h0, 16'h800A); quiet();
    chk("R2 ch3 zero count", wr_total, 32'h10000);

    // R4 R5 R8: hblank repeat channel, source rewrite while enabled
    clr();
    prog(2'd1, 32'hB000, 32'hC000, 16'd2, 16'h8150);
    repeat (10) @(negedge clk);
    chk("R5 waits for hblank", wr_total, 32'd0);
    wr(2'd1, 2'd0, 32'hD000);
    strobe(1'b1); quiet();
    chk("R4 count", wr_total, 32'd2);
    chk("R4 latched dst", log_a[1], 32'hC002);
    chk("R4 latched src data", log_d[1], expd(32'hB002, 1'b0));
    chk("R8 still enabled", {31'h0, rdback(2'd1)[15]}, 32'd1);
    strobe(1'b1); quiet();
    chk("R8 reload count", wr_total, 32'd4);
    chk("R8 dst continues", log_a[2], 32'hC004);
    chk("R8 src continues", log_d[2], expd(32'hB004, 1'b0));
    chk("R9 two pulses", irq_cnt[1], 32'd2);

    // R8: destination reload, R9 no irq when bit 8 clear
    wr(2'd1, 2'd3, 32'h0);
    clr();
    prog(2'd1, 32'hF000, 32'hE000, 16'd1, 16'h8053);
    strobe(1'b1); quiet(); strobe(1'b1); quiet();
    chk("R8 runs twice", wr_total, 32'd2);
    chk("R8 dst reloaded", log_a[1], 32'hE000);
    chk("R8 src advances", log_d[1], expd(32'hF002, 1'b0));
    chk("R9 irq masked", irq_cnt[1], 32'd0);

    // R6: vblank arms only matching channels; lower number first
    wr(2'd1, 2'd3, 32'h0);
    clr();
    prog(2'd3, 32'h300, 32'h13000, 16'd1, 16'h8180);
    prog(2'd2, 32'h200, 32'h12000, 16'd1, 16'h8180);
    prog(2'd1, 32'h100, 32'h11000, 16'd1, 16'h8140);
    prog(2'd0, 32'h000, 32'h10000, 16'd1, 16'h8180);
    strobe(1'b0); quiet();
    chk("R6 only vblank chans", wr_total, 32'd3);
    chk("R6 first ch0", log_a[0], 32'h10000);
    chk("R6 then ch2", log_a[1], 32'h12000);
    chk("R6 then ch3", log_a[2], 32'h13000);

    // R10: disable before trigger
    clr();
    wr(2'd1, 2'd3, 32'h0040);
    strobe(1'b1); quiet();
    chk("R10 no transfer", wr_total, 32'd0);

    // R5: special start code never runs
    clr();
    prog(2'd0, 32'h400, 32'h500, 16'd1, 16'h80C0);
    strobe(1'b1); strobe(1'b0); quiet();
    chk("R5 special ignored", wr_total, 32'd0);
    wr(2'd0, 2'd3, 32'h0);

    // R8: immediate start with repeat runs once, stays enabled
    clr();
    prog(2'd2, 32'h600, 32'h700, 16'd2, 16'h8110);
    quiet(); strobe(1'b1); quiet();
    chk("R8 immediate repeat once", wr_total, 32'd2);
    chk("R8 immediate stays enabled", {31'h0, rdback(2'd2)[15]}, 32'd1);

    chk("R9 pulse width", irq_wide_err, 32'd0);
    summary();
  end
endmodule